// File: doc/BRIEF.md
# Machine Sub-Mode Tracker

This block records which kind of machine-mode activity a core is in: ordinary execution, exception handling, non-maskable interrupt handling, or interrupt handling. It holds a current sub-mode and the sub-mode that was active before the last trap entry. Both live in one 32-bit control register.

The trap logic of the core pulses one of three entry strobes when it takes a trap. On entry, the current sub-mode moves into the previous field and the new sub-mode is loaded. A return strobe brings the previous sub-mode back into the current field.

Software sees the register through a combinational read port. It can change only the previous-sub-mode field, through a write port. The current sub-mode is also driven on dedicated outputs for neighbouring logic.

Top module: `msubm_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both sub-mode fields are 0 (normal) and the read data is zero.
- R2: Sub-mode codes are 2 bits: 0 normal, 1 interrupt, 2 exception, 3 NMI. The read data carries the current field in bits [7:6] and the previous field in bits [9:8]. Every other bit reads as zero, whatever was written.
- R3: An exception strobe with no NMI strobe sets the current field to 2 on the next cycle.
- R4: An NMI strobe sets the current field to 3 on the next cycle.
- R5: An interrupt strobe alone (no NMI, no exception strobe) sets the current field to 1 on the next cycle.
- R6: On any trap entry, the previous field takes the old current value in the same update. When several entry strobes coincide, NMI wins over exception, and exception wins over interrupt.
- R7: A trap entry overrides a return strobe and a register write in the same cycle. The write data is then discarded.
- R8: A return strobe without a trap entry copies the previous field into the current field and leaves the previous field unchanged, unless a write occurs in the same cycle.
- R9: A register write without a trap entry loads bits [9:8] of the write data into the previous field. The current field is not writable.
- R10: With no strobe and no write, both fields hold their values.
- R11: A return and a write in the same cycle, without a trap, take the current field from the old previous value and the previous field from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_exc | input | 1 | Exception trap entry strobe |
| trap_nmi | input | 1 | NMI trap entry strobe |
| trap_irq | input | 1 | Interrupt trap entry strobe |
| trap_ret | input | 1 | Trap return strobe |
| csr_we | input | 1 | Register write enable |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| cur_submode | output | 2 | Current sub-mode |
| prev_submode | output | 2 | Previous sub-mode |

## Verification
The assertions assume that every strobe and the write enable are at a known 0 or 1 on each clock edge after reset. They place no limit on how strobes combine, so they also hold when entry, return and write all arrive together. The bench keeps all controls low through reset and changes them only on the falling edge. Its random phase then mixes coincident strobes freely, so the priority rules are covered as well as the single-event paths.

// File: rtl/msubm_tracker.sv
module msubm_tracker #(
  parameter int XLEN     = 32,
  parameter int MODE_W   = 2,
  parameter int TYP_LSB  = 6,
  parameter int PTYP_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_exc,
  input  logic              trap_nmi,
  input  logic              trap_irq,
  input  logic              trap_ret,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic [MODE_W-1:0] cur_submode,
  output logic [MODE_W-1:0] prev_submode
);

  localparam logic [MODE_W-1:0] SM_NORM = MODE_W'(0);
  localparam logic [MODE_W-1:0] SM_IRQ  = MODE_W'(1);
  localparam logic [MODE_W-1:0] SM_EXC  = MODE_W'(2);
  localparam logic [MODE_W-1:0] SM_NMI  = MODE_W'(3);

  logic [MODE_W-1:0] typ_q, ptyp_q, entry_mode;
  logic              entry;

  assign entry = trap_nmi | trap_exc | trap_irq;

  always_comb begin
    if (trap_nmi)      entry_mode = SM_NMI;
    else if (trap_exc) entry_mode = SM_EXC;
    else if (trap_irq) entry_mode = SM_IRQ;
    else               entry_mode = SM_NORM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      typ_q  <= SM_NORM;
      ptyp_q <= SM_NORM;
    end else if (entry) begin
      typ_q  <= entry_mode;
      ptyp_q <= typ_q;
    end else begin
      if (trap_ret) typ_q  <= ptyp_q;
      if (csr_we)   ptyp_q <= csr_wdata[PTYP_LSB +: MODE_W];
    end
  end

  always_comb begin
    csr_rdata = '0;
    csr_rdata[TYP_LSB  +: MODE_W] = typ_q;
    csr_rdata[PTYP_LSB +: MODE_W] = ptyp_q;
  end

  assign cur_submode  = typ_q;
  assign prev_submode = ptyp_q;

  // R3
  exc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_exc && !trap_nmi) |=> cur_submode == SM_EXC);
  // R4
  nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_nmi |=> cur_submode == SM_NMI);
  // R5
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_irq && !trap_exc && !trap_nmi) |=> cur_submode == SM_IRQ);
  // R6
  save_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> prev_submode == $past(cur_submode));
  // R8
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !entry) |=> cur_submode == $past(prev_submode));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry && !trap_ret && !csr_we) |=> ($stable(cur_submode) && $stable(prev_submode)));
  // R2
  always_comb begin
    rsvd_zero_chk: assert ((csr_rdata & ~((((XLEN)'(1) << MODE_W) - 1) << TYP_LSB)
                            & ~((((XLEN)'(1) << MODE_W) - 1) << PTYP_LSB)) == '0);
  end

endmodule

// File: tb/msubm_tracker_test.sv
`timescale 1ns/1ps
module msubm_tracker_test;
  logic clk = 0, rst_n = 0;
  logic trap_exc = 0, trap_nmi = 0, trap_irq = 0, trap_ret = 0, csr_we = 0;
  logic [31:0] csr_wdata = 0;
  logic [31:0] csr_rdata;
  logic [1:0]  cur_submode, prev_submode;

  int checks = 0, fails = 0;
  int m_typ = 0, m_ptyp = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msubm_tracker uut (.clk, .rst_n, .trap_exc, .trap_nmi, .trap_irq, .trap_ret,
                     .csr_we, .csr_wdata, .csr_rdata, .cur_submode, .prev_submode);

  task automatic compare(string req);
    logic [31:0] exp;
    exp = 32'((m_typ << 6) | (m_ptyp << 8));
    checks++;
    if (csr_rdata !== exp || cur_submode !== 2'(m_typ) || prev_submode !== 2'(m_ptyp)) begin
      fails++;
      $display("FAIL %s: rdata=%h cur=%0d prev=%0d expected rdata=%h cur=%0d prev=%0d",
               req, csr_rdata, cur_submode, prev_submode, exp, m_typ, m_ptyp);
    end
  endtask

  task automatic step(bit e, bit n, bit i, bit r, bit w, logic [31:0] d, string req);
    int ntyp, nptyp;
    trap_exc = e; trap_nmi = n; trap_irq = i; trap_ret = r; csr_we = w; csr_wdata = d;
    @(posedge clk);
    ntyp = m_typ; nptyp = m_ptyp;
    if (n || e || i) begin
      ntyp  = n ? 3 : (e ? 2 : 1);
      nptyp = m_typ;
    end else begin
      if (r) ntyp = m_ptyp;
      if (w) nptyp = int'(d[9:8]);
    end
    m_typ = ntyp; m_ptyp = nptyp;
    @(negedge clk);
    trap_exc = 0; trap_nmi = 0; trap_irq = 0; trap_ret = 0; csr_we = 0;
    compare(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    step(0,0,0,0,0,0,            "R10");
    step(1,0,0,0,0,0,            "R3");
    step(0,0,0,1,0,0,            "R8");
    step(0,1,0,0,0,0,            "R4");
    step(0,0,1,0,0,0,            "R5");
    step(0,0,0,0,0,0,            "R10");
    step(1,1,1,0,0,0,            "R6");
    step(1,0,1,0,0,0,            "R6");
    step(0,0,1,1,1,32'h300,      "R7");
    step(0,0,0,0,1,32'hFFFF_FCFF,"R9");
    step(0,0,0,0,1,32'hFFFF_FFFF,"R2");
    step(0,0,0,1,0,0,            "R8");
    step(0,0,0,1,1,32'h100,      "R11");
    step(0,0,0,0,0,0,            "R10");
    for (int k = 0; k < 3000; k++) begin
      bit e, n, i, r, w;
      string tag;
      e = ($urandom % 6) == 0; n = ($urandom % 8) == 0; i = ($urandom % 5) == 0;
      r = ($urandom % 4) == 0; w = ($urandom % 4) == 0;
      if (n)                   tag = "R4";
      else if (e)              tag = "R3";
      else if (i)              tag = "R5";
      else if (r && w)         tag = "R11";
      else if (r)              tag = "R8";
      else if (w)              tag = "R9";
      else                     tag = "R10";
      step(e, n, i, r, w, $urandom, tag);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule